// File: doc/BRIEF.md
# Condition Code Update Unit

This unit owns the 8-bit condition code register of a small 8-bit processor core. On every cycle that `upd_en` is high it takes an instruction-class code, the two ALU operands, the ALU result, the carry and half-carry outputs, a 16-bit index-register result and an 8-bit CCR source value. From these it decides which flags that class may write, works out their new values, and registers the updated CCR. It computes no arithmetic results of its own. The one exception is the compare class, which forms the difference of the operands itself.

The five status flags are carry (C), overflow (V), zero (Z), negative (N) and half carry (H). The unit also holds three control bits: the maskable interrupt mask (I), the non-maskable interrupt mask (X) and the stop-disable bit (S). The X bit follows an asymmetric rule. Only reset or a non-maskable interrupt acknowledge can set it. A CCR load, whether from accumulator A or from the stack, can clear it but never set it. The unit also decides whether a stop command may really halt the core.

Top module: `cc_flag_unit`

## Requirements
- R1: Half carry (`ccr_q[5]`) is written only by class 2 (add with half carry, taking `half_carry`) and class 7 (CCR load). Every other class leaves it unchanged.
- R2: Class 1 (load/store) sets N to `result[7]` and Z to result equal zero, and clears V. C, H, I, X and S are unchanged.
- R3: Class 0 (push, pull, add B to index, transfer, exchange) and the unused codes 11 to 15 leave the whole CCR unchanged, whatever the operands.
- R4: Class 6 (index increment or decrement) sets Z when `idx_result` is zero. No other bit changes, and the 8-bit result is ignored.
- R5: Classes 2 and 3 (add) set C from `carry_out`. V is set when `op_a[7]` equals `op_b[7]` and `result[7]` differs from them. N and Z come from the result.
- R6: Class 4 (subtract `op_a - op_b`) sets C from `carry_out`, which acts as the borrow. V is set when the operand signs differ and `result[7]` differs from `op_a[7]`. N and Z come from the result.
- R7: Class 5 (compare) forms `op_a - op_b` internally and ignores `result`, `carry_out` and `half_carry`. N, Z and V follow that difference, and C is set when `op_a` is below `op_b` unsigned.
- R8: Class 10 (stop) raises `stop_enter` in the same cycle only while S is clear. With S set it acts as a no-operation, and it never changes the CCR.
- R9: Reset, an asynchronous active-low input, sets `ccr_q` to 8'hD0. The bit layout from bit 7 down is S, X, H, I, N, Z, V, C.
- R10: Class 7 (CCR load) copies `ccr_in` into every bit, except that the new X is the old X ANDed with `ccr_in[6]`.
- R11: Class 8 (interrupt acknowledge) sets I. Class 9 (non-maskable acknowledge) sets both I and X. All other bits hold.
- R12: While `upd_en` is low the CCR holds, whatever the class and data inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Apply the given class this cycle |
| op_class | input | 4 | Instruction-class code |
| op_a | input | DW | First ALU operand (minuend for subtract and compare) |
| op_b | input | DW | Second ALU operand |
| result | input | DW | ALU result |
| carry_out | input | 1 | ALU carry or borrow out of the top bit |
| half_carry | input | 1 | ALU carry from bit 3 into bit 4 |
| idx_result | input | IW | Result of an index increment or decrement |
| ccr_in | input | 8 | CCR source for a load from A or a stack restore |
| ccr_q | output | 8 | Condition code register |
| stop_enter | output | 1 | Stop command accepted this cycle |

## Verification
The bench targets the places where a class might write more flags than it should:
- An add without half carry that clobbers H.
- An index step that takes Z from the 8-bit result or disturbs the other flags.
- A compare that trusts the external result and carry, which would report a wrong borrow and zero.
- The overflow rules, checked with operands that cross the sign boundary in both directions.

It also drives a CCR load of all ones while X is clear, which a design with a symmetric X rule would get wrong by setting X. It drives stop commands with S both clear and set. Finally it applies class and data inputs while the unit is not enabled, to show the register really holds.

// File: rtl/cc_pkg.sv
package cc_pkg;
  // instruction-class codes
  localparam logic [3:0] CL_KEEP  = 4'd0;
  localparam logic [3:0] CL_MOVE  = 4'd1;
  localparam logic [3:0] CL_ADDH  = 4'd2;
  localparam logic [3:0] CL_ADD   = 4'd3;
  localparam logic [3:0] CL_SUB   = 4'd4;
  localparam logic [3:0] CL_CMP   = 4'd5;
  localparam logic [3:0] CL_IDX   = 4'd6;
  localparam logic [3:0] CL_CCRLD = 4'd7;
  localparam logic [3:0] CL_IACK  = 4'd8;
  localparam logic [3:0] CL_XACK  = 4'd9;
  localparam logic [3:0] CL_STOP  = 4'd10;

  // register bit positions
  localparam int unsigned B_S = 7;
  localparam int unsigned B_X = 6;
  localparam int unsigned B_H = 5;
  localparam int unsigned B_I = 4;
  localparam int unsigned B_N = 3;
  localparam int unsigned B_Z = 2;
  localparam int unsigned B_V = 1;
  localparam int unsigned B_C = 0;

  localparam logic [7:0] CCR_RST = 8'hD0;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } stat_t;

  // signed overflow of a + b, from the sign bits
  function automatic logic add_ovf(input logic am, input logic bm, input logic rm);
    return (am == bm) && (rm != am);
  endfunction

  // signed overflow of a - b, from the sign bits
  function automatic logic sub_ovf(input logic am, input logic bm, input logic rm);
    return (am != bm) && (rm != am);
  endfunction
endpackage

// File: rtl/cc_flag_calc.sv
module cc_flag_calc
  import cc_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 16
) (
  input  logic [3:0]    op_class,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] result,
  input  logic          carry_out,
  input  logic          half_carry,
  input  logic [IW-1:0] idx_result,
  input  stat_t         load_stat,
  input  stat_t         cur,
  output stat_t         nxt
);
  localparam int unsigned MSB = DW - 1;

  logic [DW-1:0] cmp_diff;
  logic          cmp_borrow;

  assign cmp_diff   = op_a - op_b;
  assign cmp_borrow = (op_a < op_b);

  always_comb begin
    nxt = cur;
    case (op_class)
      CL_MOVE: begin
        nxt.n = result[MSB];
        nxt.z = ~|result;
        nxt.v = 1'b0;
      end
      CL_ADDH, CL_ADD: begin
        if (op_class == CL_ADDH) nxt.h = half_carry;
        nxt.n = result[MSB];
        nxt.z = ~|result;
        nxt.v = add_ovf(op_a[MSB], op_b[MSB], result[MSB]);
        nxt.c = carry_out;
      end
      CL_SUB: begin
        nxt.n = result[MSB];
        nxt.z = ~|result;
        nxt.v = sub_ovf(op_a[MSB], op_b[MSB], result[MSB]);
        nxt.c = carry_out;
      end
      CL_CMP: begin
        nxt.n = cmp_diff[MSB];
        nxt.z = ~|cmp_diff;
        nxt.v = sub_ovf(op_a[MSB], op_b[MSB], cmp_diff[MSB]);
        nxt.c = cmp_borrow;
      end
      CL_IDX:   nxt.z = ~|idx_result;
      CL_CCRLD: nxt = load_stat;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/cc_ctrl_bits.sv
module cc_ctrl_bits
  import cc_pkg::*;
(
  input  logic       upd_en,
  input  logic [3:0] op_class,
  input  logic       ld_s,
  input  logic       ld_x,
  input  logic       ld_i,
  input  logic       s_q,
  input  logic       x_q,
  input  logic       i_q,
  output logic       s_n,
  output logic       x_n,
  output logic       i_n,
  output logic       xset_ack,
  output logic       stop_go
);
  assign xset_ack = upd_en && (op_class == CL_XACK);
  assign stop_go  = upd_en && (op_class == CL_STOP) && !s_q;

  always_comb begin
    s_n = s_q;
    x_n = x_q;
    i_n = i_q;
    case (op_class)
      CL_CCRLD: begin
        s_n = ld_s;
        x_n = x_q & ld_x;   // a load may clear X, never set it
        i_n = ld_i;
      end
      CL_IACK: i_n = 1'b1;
      CL_XACK: begin
        i_n = 1'b1;
        x_n = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cc_flag_unit.sv
module cc_flag_unit
  import cc_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [3:0]    op_class,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] result,
  input  logic          carry_out,
  input  logic          half_carry,
  input  logic [IW-1:0] idx_result,
  input  logic [7:0]    ccr_in,
  output logic [7:0]    ccr_q,
  output logic          stop_enter
);
  stat_t stat_cur, stat_nxt, stat_load;
  logic  s_n, x_n, i_n;
  logic  xset_ack;
  logic  [7:0] ccr_nxt;

  assign stat_cur  = '{h: ccr_q[B_H], n: ccr_q[B_N], z: ccr_q[B_Z], v: ccr_q[B_V], c: ccr_q[B_C]};
  assign stat_load = '{h: ccr_in[B_H], n: ccr_in[B_N], z: ccr_in[B_Z], v: ccr_in[B_V], c: ccr_in[B_C]};

  cc_flag_calc #(.DW(DW), .IW(IW)) u_calc (
    .op_class  (op_class),
    .op_a      (op_a),
    .op_b      (op_b),
    .result    (result),
    .carry_out (carry_out),
    .half_carry(half_carry),
    .idx_result(idx_result),
    .load_stat (stat_load),
    .cur       (stat_cur),
    .nxt       (stat_nxt)
  );

  cc_ctrl_bits u_ctrl (
    .upd_en  (upd_en),
    .op_class(op_class),
    .ld_s    (ccr_in[B_S]),
    .ld_x    (ccr_in[B_X]),
    .ld_i    (ccr_in[B_I]),
    .s_q     (ccr_q[B_S]),
    .x_q     (ccr_q[B_X]),
    .i_q     (ccr_q[B_I]),
    .s_n     (s_n),
    .x_n     (x_n),
    .i_n     (i_n),
    .xset_ack(xset_ack),
    .stop_go (stop_enter)
  );

  assign ccr_nxt = {s_n, x_n, stat_nxt.h, i_n, stat_nxt.n, stat_nxt.z, stat_nxt.v, stat_nxt.c};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ccr_q <= CCR_RST;
    else if (upd_en) ccr_q <= ccr_nxt;
  end
endmodule

// File: rtl/cc_flag_unit_chk.sv
module cc_flag_unit_chk
  import cc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       upd_en,
  input logic [3:0] op_class,
  input logic [7:0] ccr_q,
  input logic       stop_enter,
  input logic       xset_ack
);
  AST_H_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_en && (op_class == CL_ADDH || op_class == CL_CCRLD)) |=> $stable(ccr_q[B_H])); // R1
  AST_MOVE_CLEARS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_class == CL_MOVE) |=> !ccr_q[B_V]); // R2
  AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_class == CL_KEEP) |=> $stable(ccr_q)); // R3
  AST_IDX_ONLY_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_class == CL_IDX) |=>
      (ccr_q[7:3] == $past(ccr_q[7:3])) && (ccr_q[1:0] == $past(ccr_q[1:0]))); // R4
  AST_STOP_NEEDS_S_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stop_enter |-> !ccr_q[B_S]); // R8
  AST_STOP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_class == CL_STOP) |=> $stable(ccr_q)); // R8
  AST_X_RISE_ONLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ccr_q[B_X]) |-> $past(xset_ack)); // R10
  AST_XACK_SETS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    xset_ack |=> ccr_q[B_X] && ccr_q[B_I]); // R11
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(ccr_q)); // R12
endmodule

bind cc_flag_unit cc_flag_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_en    (upd_en),
  .op_class  (op_class),
  .ccr_q     (ccr_q),
  .stop_enter(stop_enter),
  .xset_ack  (xset_ack)
);

// File: tb/cc_flag_unit_bench.sv
module cc_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 1'b0;
  logic [3:0]  op_class = '0;
  logic [7:0]  op_a = '0, op_b = '0, result = '0, ccr_in = '0;
  logic        carry_out = 1'b0, half_carry = 1'b0;
  logic [15:0] idx_result = '0;
  logic [7:0]  ccr_q;
  logic        stop_enter;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cc_flag_unit u_cc_flag_unit (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
    .op_a(op_a), .op_b(op_b), .result(result), .carry_out(carry_out),
    .half_carry(half_carry), .idx_result(idx_result), .ccr_in(ccr_in),
    .ccr_q(ccr_q), .stop_enter(stop_enter)
  );

  // fields: class, a, b, result, carry, half, idx, ccr_in, expected ccr, requirement
  localparam int NV = 17;
  localparam logic [69:0] VEC [NV] = '{
    {4'd7,  8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h00, 8'd10}, // R10 clear all
    {4'd2,  8'h08, 8'h08, 8'h10, 1'b0, 1'b1, 16'h0000, 8'h00, 8'h20, 8'd1},  // R1 half carry
    {4'd2,  8'h7F, 8'h01, 8'h80, 1'b0, 1'b1, 16'h0000, 8'h00, 8'h2A, 8'd5},  // R5 positive overflow
    {4'd3,  8'hFF, 8'h01, 8'h00, 1'b1, 1'b1, 16'h0000, 8'h00, 8'h25, 8'd5},  // R5 carry, zero, H kept
    {4'd4,  8'h80, 8'h01, 8'h7F, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h22, 8'd6},  // R6 sub overflow
    {4'd1,  8'h00, 8'h00, 8'h9A, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h28, 8'd2},  // R2 V cleared
    {4'd5,  8'h10, 8'h20, 8'h55, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h29, 8'd7},  // R7 borrow
    {4'd5,  8'h33, 8'h33, 8'hFF, 1'b1, 1'b1, 16'h0000, 8'h00, 8'h24, 8'd7},  // R7 equal
    {4'd6,  8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 16'h0100, 8'h00, 8'h20, 8'd4},  // R4 nonzero index
    {4'd6,  8'h00, 8'h00, 8'h55, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h24, 8'd4},  // R4 zero index
    {4'd0,  8'hFF, 8'hFF, 8'h00, 1'b1, 1'b1, 16'h0000, 8'hFF, 8'h24, 8'd3},  // R3 keep
    {4'd13, 8'hFF, 8'hFF, 8'h00, 1'b1, 1'b1, 16'h0000, 8'hFF, 8'h24, 8'd3},  // R3 unused code
    {4'd8,  8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h34, 8'd11}, // R11 I set
    {4'd7,  8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 8'hFF, 8'hBF, 8'd10}, // R10 X not set by load
    {4'd9,  8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00, 8'hFF, 8'd11}, // R11 X and I set
    {4'd7,  8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h00, 8'd10}, // R10 X cleared by load
    {4'd4,  8'h05, 8'h07, 8'hFE, 1'b1, 1'b0, 16'h0000, 8'h00, 8'h09, 8'd6}   // R6 borrow
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic [3:0] cls, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] r, input logic co, input logic hc, input logic [15:0] ix,
                       input logic [7:0] ci);
    upd_en = en; op_class = cls; op_a = a; op_b = b; result = r;
    carry_out = co; half_carry = hc; idx_result = ix; ccr_in = ci;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", ccr_q, 8'hD0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(1'b1, VEC[k][69:66], VEC[k][65:58], VEC[k][57:50], VEC[k][49:42],
            VEC[k][41], VEC[k][40], VEC[k][39:24], VEC[k][23:16]);
      @(negedge clk);
      drive(1'b0, 4'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00);
      chk($sformatf("R%0d", VEC[k][7:0]), ccr_q, VEC[k][15:8]);
    end

    // R8: stop with S clear is accepted and leaves the flags alone
    @(negedge clk);
    drive(1'b1, 4'd10, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00);
    #1 chk("R8", {7'd0, stop_enter}, 8'h01);
    @(negedge clk);
    chk("R8", ccr_q, 8'h09);
    drive(1'b1, 4'd7, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h80);
    @(negedge clk);
    chk("R10", ccr_q, 8'h80);
    // R8: stop with S set is a no-operation
    drive(1'b1, 4'd10, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00);
    #1 chk("R8", {7'd0, stop_enter}, 8'h00);
    @(negedge clk);
    chk("R8", ccr_q, 8'h80);

    // R12: disabled cycles hold the register
    drive(1'b0, 4'd2, 8'h7F, 8'h7F, 8'h00, 1'b1, 1'b1, 16'h0000, 8'h00);
    @(negedge clk);
    chk("R12", ccr_q, 8'h80);
    drive(1'b0, 4'd9, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00);
    @(negedge clk);
    chk("R12", ccr_q, 8'h80);

    // R9: reset in mid-run acts at once
    rst_n = 1'b0;
    #1 chk("R9", ccr_q, 8'hD0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 4'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 8'h00);
    @(negedge clk);
    chk("R9", ccr_q, 8'hD0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule